// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block drives the strobes of a single-bus processor datapath from a small step counter. The counter value is decoded into one-hot step lines. The opcode held in the datapath's instruction register is decoded into one line per instruction class. Each strobe is a sum of products of those lines, and the negative flag is one extra term. Every instruction starts with the same three fetch steps. After that, the instruction's own steps run until the finish strobe returns the counter to the first step.

The datapath reports the end of a memory access with a completion input. In a step that waits on memory, the counter stops advancing until that input is high, and the strobes for that step stay asserted while it waits. Three instructions are decoded: an add whose first operand comes from memory through an address register, a relative jump, and a jump taken only when the result was negative. Any other opcode finishes right after fetch and writes nothing.

Top module: `hw_step_ctrl`

## Requirements
- R1: Exactly one bit of `step_hot` is high in every cycle. Bit k means step T(k+1). While `rst` is high and in the first cycle after it, T1 is the active step.
- R2: Every opcode gets the same fetch strobes. In T1: `pc_out`, `mar_in`, `mem_read`, `carry_in`, `alu_add`, `z_in`. In T2: `z_out`, `pc_in`, `wait_mfc`. In T3: `mdr_out`, `ir_in`. No other strobe is high in these steps.
- R3: In a step with `wait_mfc` high, the step and its strobes are held for as long as `mfc` is low. The counter moves on in the first cycle in which `mfc` is high. In steps without `wait_mfc`, `mfc` has no effect.
- R4: Opcode 4'h1 (memory add) runs four more steps. T4: `rf_out` with `rf_sel`=3, `mar_in`, `mem_read`. T5: `rf_out` with `rf_sel`=1, `y_in`, `wait_mfc`. T6: `mdr_out`, `alu_add`, `z_in`. T7: `z_out`, `rf_in` with `rf_sel`=1, `end_op`.
- R5: Opcode 4'h2 (jump) runs three more steps. T4: `pc_out`, `y_in`. T5: `off_out`, `alu_add`, `z_in`. T6: `z_out`, `pc_in`, `end_op`.
- R6: Opcode 4'h3 (jump if negative) with `n_flag`=1 produces the same T4 to T6 strobes as R5 and finishes in T6.
- R7: Opcode 4'h3 with `n_flag`=0 finishes in T4. The strobes in that step are only `pc_out`, `y_in` and `end_op`.
- R8: The cycle after any cycle with `end_op` high is always step T1.
- R9: Any other opcode asserts only `end_op` in T4. In that step `pc_in`, `rf_in`, `ir_in`, `mar_in`, `mem_read` and every other strobe stay low.
- R10: In every cycle, at most one of `pc_out`, `z_out`, `mdr_out`, `off_out`, `rf_out` is high, and `z_in` and `z_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W | Opcode field from the instruction register |
| n_flag | input | 1 | Negative status flag |
| mfc | input | 1 | Memory access complete |
| step_hot | output | N_STEPS | One-hot current step |
| pc_out | output | 1 | PC drives bus |
| pc_in | output | 1 | PC loads from bus |
| mar_in | output | 1 | Memory address register loads |
| mem_read | output | 1 | Start memory read |
| carry_in | output | 1 | ALU carry-in set |
| alu_add | output | 1 | ALU performs add |
| y_in | output | 1 | Y operand register loads |
| z_in | output | 1 | Z result register loads |
| z_out | output | 1 | Z drives bus |
| ir_in | output | 1 | Instruction register loads |
| mdr_out | output | 1 | Memory data register drives bus |
| off_out | output | 1 | Offset field of IR drives bus |
| rf_out | output | 1 | Register file drives bus |
| rf_in | output | 1 | Register file loads from bus |
| rf_sel | output | RF_AW | Register file address for rf_out/rf_in |
| wait_mfc | output | 1 | Current step waits for mfc |
| end_op | output | 1 | Last step of the instruction |

## Verification
Each opcode class is run with every relevant flag value. The full strobe word is compared with the expected word in each step, so any missing or extra product term shows up in the step where it belongs. Memory completion delays of zero, one, two and three cycles show that the wait steps (T2, and T5 of the add) hold correctly, and that the counter never stalls on steps that do not wait. Two pairs tell specific faults apart. The negative jump is run with the flag both set and clear, which separates an early finish at T4 from the full run to T6. Two different unknown opcodes separate a clean finish from a stray write. A reset during a stalled wait checks that the sequence restarts at T1.

// File: rtl/hw_step_ctrl_pkg.sv
package hw_step_ctrl_pkg;

  // instruction-class line indices produced by the opcode decoder
  localparam int INS_ADD = 0;
  localparam int INS_BR  = 1;
  localparam int INS_BRN = 2;
  localparam int INS_BAD = 3;
  localparam int INS_N   = 4;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mem_read;
    logic carry_in;
    logic alu_add;
    logic y_in;
    logic z_in;
    logic z_out;
    logic ir_in;
    logic mdr_out;
    logic off_out;
    logic rf_out;
    logic rf_in;
    logic wait_mfc;
    logic fin;
  } strobe_t;

endpackage

// File: rtl/hsc_step_counter.sv
module hsc_step_counter #(
  parameter int N_STEPS = 7,
  localparam int STEP_W = $clog2(N_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              fin,
  output logic [STEP_W-1:0] cnt
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst || fin)
      cnt <= '0;
    else if (run && cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  // R8: finishing returns the counter to the first step
  a_r8_fin_restart: assert property (@(posedge clk) disable iff (rst)
    fin |=> cnt == '0);
  // R3: a stalled step keeps its count
  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (!run && !fin) |=> $stable(cnt));
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (run && !fin && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/hsc_step_decoder.sv
module hsc_step_decoder #(
  parameter int N_STEPS = 7,
  localparam int STEP_W = $clog2(N_STEPS)
) (
  input  logic [STEP_W-1:0]  cnt,
  output logic [N_STEPS-1:0] hot
);
  for (genvar i = 0; i < N_STEPS; i++) begin : g_line
    assign hot[i] = (cnt == STEP_W'(i));
  end
endmodule

// File: rtl/hsc_instr_decoder.sv
module hsc_instr_decoder
  import hw_step_ctrl_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int OPC_ADD = 1,
  parameter int OPC_BR  = 2,
  parameter int OPC_BRN = 3
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [INS_N-1:0] ins
);
  always_comb begin
    ins = '0;
    unique case (opcode)
      OPC_W'(OPC_ADD): ins[INS_ADD] = 1'b1;
      OPC_W'(OPC_BR):  ins[INS_BR]  = 1'b1;
      OPC_W'(OPC_BRN): ins[INS_BRN] = 1'b1;
      default:         ins[INS_BAD] = 1'b1;
    endcase
  end
endmodule

// File: rtl/hsc_strobe_encoder.sv
module hsc_strobe_encoder
  import hw_step_ctrl_pkg::*;
#(
  parameter int N_STEPS = 7,
  parameter int RF_AW   = 2,
  parameter int SRC_REG = 3,
  parameter int DST_REG = 1
) (
  input  logic [N_STEPS-1:0] t,
  input  logic [INS_N-1:0]   ins,
  input  logic               n_flag,
  output strobe_t            s,
  output logic [RF_AW-1:0]   rf_sel
);
  logic add, br, brn, bad, jmp;

  always_comb begin
    add = ins[INS_ADD];
    br  = ins[INS_BR];
    brn = ins[INS_BRN];
    bad = ins[INS_BAD];
    jmp = br | brn;

    s.pc_out   = t[0] | (t[3] & jmp);
    s.pc_in    = t[1] | (t[5] & jmp);
    s.mar_in   = t[0] | (t[3] & add);
    s.mem_read = t[0] | (t[3] & add);
    s.carry_in = t[0];
    s.alu_add  = t[0] | (t[5] & add) | (t[4] & jmp);
    s.y_in     = (t[4] & add) | (t[3] & jmp);
    s.z_in     = t[0] | (t[5] & add) | (t[4] & jmp);
    s.z_out    = t[1] | (t[6] & add) | (t[5] & jmp);
    s.ir_in    = t[2];
    s.mdr_out  = t[2] | (t[5] & add);
    s.off_out  = t[4] & jmp;
    s.rf_out   = (t[3] | t[4]) & add;
    s.rf_in    = t[6] & add;
    s.wait_mfc = t[1] | (t[4] & add);
    s.fin      = (t[6] & add) | (t[5] & br)
               | (((t[5] & n_flag) | (t[3] & ~n_flag)) & brn)
               | (t[3] & bad);

    if (s.rf_out || s.rf_in)
      rf_sel = t[3] ? RF_AW'(SRC_REG) : RF_AW'(DST_REG);
    else
      rf_sel = '0;
  end
endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import hw_step_ctrl_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter int N_STEPS = 7,
  parameter int RF_AW   = 2,
  parameter int OPC_ADD = 1,
  parameter int OPC_BR  = 2,
  parameter int OPC_BRN = 3,
  parameter int SRC_REG = 3,
  parameter int DST_REG = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               n_flag,
  input  logic               mfc,
  output logic [N_STEPS-1:0] step_hot,
  output logic               pc_out,
  output logic               pc_in,
  output logic               mar_in,
  output logic               mem_read,
  output logic               carry_in,
  output logic               alu_add,
  output logic               y_in,
  output logic               z_in,
  output logic               z_out,
  output logic               ir_in,
  output logic               mdr_out,
  output logic               off_out,
  output logic               rf_out,
  output logic               rf_in,
  output logic [RF_AW-1:0]   rf_sel,
  output logic               wait_mfc,
  output logic               end_op
);
  localparam int STEP_W = $clog2(N_STEPS);

  logic [STEP_W-1:0] cnt;
  logic [INS_N-1:0]  ins;
  strobe_t           s;
  logic              run;

  assign run = ~(s.wait_mfc & ~mfc);

  hsc_step_counter #(.N_STEPS(N_STEPS)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .fin(s.fin), .cnt(cnt)
  );

  hsc_step_decoder #(.N_STEPS(N_STEPS)) u_sdec (
    .cnt(cnt), .hot(step_hot)
  );

  hsc_instr_decoder #(
    .OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_BR(OPC_BR), .OPC_BRN(OPC_BRN)
  ) u_idec (
    .opcode(opcode), .ins(ins)
  );

  hsc_strobe_encoder #(
    .N_STEPS(N_STEPS), .RF_AW(RF_AW), .SRC_REG(SRC_REG), .DST_REG(DST_REG)
  ) u_enc (
    .t(step_hot), .ins(ins), .n_flag(n_flag), .s(s), .rf_sel(rf_sel)
  );

  assign pc_out   = s.pc_out;
  assign pc_in    = s.pc_in;
  assign mar_in   = s.mar_in;
  assign mem_read = s.mem_read;
  assign carry_in = s.carry_in;
  assign alu_add  = s.alu_add;
  assign y_in     = s.y_in;
  assign z_in     = s.z_in;
  assign z_out    = s.z_out;
  assign ir_in    = s.ir_in;
  assign mdr_out  = s.mdr_out;
  assign off_out  = s.off_out;
  assign rf_out   = s.rf_out;
  assign rf_in    = s.rf_in;
  assign wait_mfc = s.wait_mfc;
  assign end_op   = s.fin;

  // R1: exactly one step line is active
  a_r1_onehot_step: assert property (@(posedge clk) disable iff (rst)
    $countones(step_hot) == 1);
  // R10: single bus driver, no Z read and write in one step
  a_r10_one_bus_src: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, z_out, mdr_out, off_out, rf_out}));
  a_r10_z_excl: assert property (@(posedge clk) disable iff (rst)
    !(z_in && z_out));
  // R3: a waiting step keeps its strobes while memory is busy
  a_r3_wait_stable: assert property (@(posedge clk) disable iff (rst)
    (wait_mfc && !mfc) |=> $stable(step_hot));
  // R9: unknown opcodes write nothing past fetch
  a_r9_bad_no_write: assert property (@(posedge clk) disable iff (rst)
    (ins[INS_BAD] && step_hot[3]) |-> !(pc_in || rf_in || ir_in || mar_in || z_in || y_in));
  // R7: not-taken branch finishes at T4
  a_r7_brn_short: assert property (@(posedge clk) disable iff (rst)
    (ins[INS_BRN] && !n_flag && step_hot[3]) |-> end_op);

endmodule

// File: tb/hw_step_ctrl_bench.sv
module hw_step_ctrl_bench;
  localparam int N_STEPS = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'h0;
  logic       n_flag = 1'b0;
  logic       mfc = 1'b0;
  logic [N_STEPS-1:0] step_hot;
  logic pc_out, pc_in, mar_in, mem_read, carry_in, alu_add, y_in, z_in, z_out;
  logic ir_in, mdr_out, off_out, rf_out, rf_in, wait_mfc, end_op;
  logic [1:0] rf_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  hw_step_ctrl u_hw_step_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .n_flag(n_flag), .mfc(mfc),
    .step_hot(step_hot), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in),
    .mem_read(mem_read), .carry_in(carry_in), .alu_add(alu_add), .y_in(y_in),
    .z_in(z_in), .z_out(z_out), .ir_in(ir_in), .mdr_out(mdr_out),
    .off_out(off_out), .rf_out(rf_out), .rf_in(rf_in), .rf_sel(rf_sel),
    .wait_mfc(wait_mfc), .end_op(end_op)
  );

  // strobe word bit positions used only in the bench
  localparam int B_PCO = 15, B_PCI = 14, B_MAR = 13, B_RD = 12, B_CIN = 11;
  localparam int B_ADD = 10, B_YI = 9, B_ZI = 8, B_ZO = 7, B_IRI = 6;
  localparam int B_MDO = 5, B_OFF = 4, B_RFO = 3, B_RFI = 2, B_WT = 1, B_END = 0;

  function automatic logic [15:0] got_word();
    return {pc_out, pc_in, mar_in, mem_read, carry_in, alu_add, y_in, z_in,
            z_out, ir_in, mdr_out, off_out, rf_out, rf_in, wait_mfc, end_op};
  endfunction

  // expected strobes straight from the requirement text
  function automatic logic [15:0] exp_word(input logic [3:0] op, input logic n, input int st);
    logic [15:0] w = '0;
    case (st)
      1: begin w[B_PCO]=1; w[B_MAR]=1; w[B_RD]=1; w[B_CIN]=1; w[B_ADD]=1; w[B_ZI]=1; end
      2: begin w[B_ZO]=1; w[B_PCI]=1; w[B_WT]=1; end
      3: begin w[B_MDO]=1; w[B_IRI]=1; end
      default: begin
        if (op == 4'h1) begin
          case (st)
            4: begin w[B_RFO]=1; w[B_MAR]=1; w[B_RD]=1; end
            5: begin w[B_RFO]=1; w[B_YI]=1; w[B_WT]=1; end
            6: begin w[B_MDO]=1; w[B_ADD]=1; w[B_ZI]=1; end
            7: begin w[B_ZO]=1; w[B_RFI]=1; w[B_END]=1; end
            default: ;
          endcase
        end else if (op == 4'h2 || (op == 4'h3 && n)) begin
          case (st)
            4: begin w[B_PCO]=1; w[B_YI]=1; end
            5: begin w[B_OFF]=1; w[B_ADD]=1; w[B_ZI]=1; end
            6: begin w[B_ZO]=1; w[B_PCI]=1; w[B_END]=1; end
            default: ;
          endcase
        end else if (op == 4'h3) begin
          if (st == 4) begin w[B_PCO]=1; w[B_YI]=1; w[B_END]=1; end
        end else begin
          if (st == 4) w[B_END]=1;
        end
      end
    endcase
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input logic n, input int st);
    if (st <= 3) return "R2";
    if (op == 4'h1) return "R4";
    if (op == 4'h2) return "R5";
    if (op == 4'h3) return n ? "R6" : "R7";
    return "R9";
  endfunction

  // run one instruction from T1; sits at a negedge on entry and exit
  task automatic run_instr(input logic [3:0] op, input logic n, input int dly, input int len);
    int st = 1;
    int waited = 0;
    bit fin = 0;
    logic [15:0] ew;
    opcode = op;
    n_flag = n;
    while (!fin) begin
      ew  = exp_word(op, n, st);
      mfc = ew[B_WT] ? (waited >= dly) : 1'b0;
      check(waited > 0 ? "R3" : req_of(op, n, st), 32'(got_word()), 32'(ew));
      check("R1", 32'(step_hot), 32'(1 << (st - 1)));
      check("R10", 32'($countones({pc_out, z_out, mdr_out, off_out, rf_out}) <= 1 && !(z_in && z_out)), 32'd1);
      if (rf_out || rf_in)
        check(req_of(op, n, st), 32'(rf_sel), (st == 4) ? 32'd3 : 32'd1);
      if (ew[B_END]) begin
        check(req_of(op, n, st), 32'(st), 32'(len));
        fin = 1;
      end else if (ew[B_WT] && !mfc) begin
        waited++;
      end else begin
        st++;
        waited = 0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    mfc = 1'b0;
    check("R8", 32'(step_hot), 32'd1);
  endtask

  // {opcode, n, mfc delay, expected finishing step}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {4'h1, 1'b0, 4'd0, 4'd7},
    {4'h1, 1'b1, 4'd3, 4'd7},
    {4'h2, 1'b0, 4'd1, 4'd6},
    {4'h2, 1'b1, 4'd0, 4'd6},
    {4'h3, 1'b1, 4'd0, 4'd6},
    {4'h3, 1'b0, 4'd2, 4'd4},
    {4'h0, 1'b1, 4'd0, 4'd4},
    {4'hF, 1'b0, 4'd1, 4'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(step_hot), 32'd1);          // reset state, rst still high
    rst = 1'b0;
    check("R1", 32'(step_hot), 32'd1);

    for (int i = 0; i < NV; i++)
      run_instr(VEC[i][12:9], VEC[i][8], int'(VEC[i][7:4]), int'(VEC[i][3:0]));

    // reset while stalled in the add's memory wait (T5)
    opcode = 4'h1;
    n_flag = 1'b0;
    mfc    = 1'b1;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    mfc = 1'b0;
    check("R3", 32'(step_hot), 32'b0010000);
    @(posedge clk); @(negedge clk);
    check("R3", 32'(step_hot), 32'b0010000);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 32'(step_hot), 32'd1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2", 32'(step_hot), 32'b0000010);    // fetch restarted, now T2

    // mfc pulses outside a wait step change nothing: T3 follows the T2 release
    mfc = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3", 32'(step_hot), 32'b0000100);
    @(posedge clk); @(negedge clk);
    check("R4", 32'(step_hot), 32'b0001000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule